// File: doc/BRIEF.md
# RAID-6 Dual Parity Syndrome Engine

This block computes the two redundancy words of a RAID-6 stripe as data streams past it. One beat on the input carries one 16-byte column slice of one data disk, and a stripe column arrives as a run of beats that starts with the highest-numbered data disk and ends with disk 0. While the run is in flight the engine keeps two accumulators. The first is the plain XOR parity P. The second is the Reed-Solomon syndrome Q over GF(2^8) with the reduction polynomial x^8+x^4+x^3+x^2+1, built by Horner's rule. Every byte lane is computed independently and in parallel.

A run ends on the beat that brings the count of accepted beats up to the data-disk count, or on an earlier beat that carries the last marker. The data-disk count is sampled on the first beat of the run. One cycle after the closing beat, the finished P and Q appear on the outputs with a single-cycle valid strobe. Both accumulators are then cleared, so the next run begins from scratch.

The input uses a valid/ready handshake. Ready is low only while reset is asserted and high at all other times, so the engine never applies back-pressure outside reset. A source that sees ready low must hold its beat until a cycle in which valid and ready are both high. The output has no handshake: the consumer must capture P and Q on the strobe cycle or, later, from the held output registers.

Top module: `pq_syndrome_engine`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0, `out_p` and `out_q` are 0, and `in_ready` is 0. From the first clock edge after reset is released, `in_ready` stays 1.
- R2: For each closed run, `out_p` equals the bytewise XOR of all data words accepted in that run.
- R3: For each closed run, `out_q` follows Horner's rule. Q starts as the first accepted word (the highest disk). For each later word, Q is first multiplied by x and then XORed with that word. The result equals the sum of g^k·D_k, where k is the disk index (last beat = disk 0) and g = 0x02.
- R4: Multiply-by-x acts on each byte lane separately. The byte is shifted left by one, and the result is XORed with 0x1d when bit 7 of the byte was set. For example, lane 0x80 gives 0x1d and lane 0x41 gives 0x82.
- R5: With a data-disk count of 1, the run closes on its first beat, and `out_p` and `out_q` both equal that word.
- R6: `out_valid` is high for exactly the one cycle after the closing beat is accepted. `out_p` and `out_q` hold their values until the next closing beat.
- R7: `ndata` (the data-disk count, 1 to 253) is sampled on the first beat of a run. Changes to it on later beats of the same run have no effect on where the run closes.
- R8: A beat accepted with `in_last` = 1 closes the run, even if fewer than `ndata` beats have been accepted.
- R9: No accumulator state carries from one run into the next. Two runs back to back each give the result of their own words only.
- R10: Cycles with `in_valid` = 0 change nothing, whatever `in_data`, `in_last` or `ndata` carry during them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ndata | input | 8 | Number of data disks, sampled on the first beat of a run |
| in_valid | input | 1 | Input beat is present |
| in_ready | output | 1 | Engine can accept a beat (low only in reset) |
| in_data | input | 128 | One 16-byte data word, lane i in bits 8i+7:8i |
| in_last | input | 1 | This beat is disk 0; closes the run early |
| out_valid | output | 1 | One-cycle strobe: P and Q are valid |
| out_p | output | 128 | XOR parity of the run |
| out_q | output | 128 | GF(2^8) syndrome of the run |

## Verification
The assertions assume that the source never drives `in_valid` high during reset. They also assume that `in_last`, when it is used, arrives on a valid beat rather than on an idle cycle. The stimulus drives inputs only on falling edges and keeps `in_valid` low for the whole reset. During idle gaps it deliberately places junk on `in_data`, `in_last` and `ndata`, so that the R10 checks look at what the engine ignores. The data-disk counts used by the stimulus stay within 1 to 253, and runs are always longer than one beat whenever the count exceeds 1.

// File: rtl/pq_pkg.sv
`timescale 1ns/1ps
package pq_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam logic [7:0]  RED_POLY = 8'h1d;
  localparam int unsigned CNT_W    = 8;
endpackage

// File: rtl/pq_xtime.sv
`timescale 1ns/1ps
// Byte-parallel multiply by x in GF(2^8), one independent unit per lane.
module pq_xtime #(
  parameter int unsigned LANES = 16
) (
  input  logic [LANES*pq_pkg::BYTE_W-1:0] a,
  output logic [LANES*pq_pkg::BYTE_W-1:0] y
);
  localparam int unsigned BW = pq_pkg::BYTE_W;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [BW-1:0] b;
    assign b = a[i*BW +: BW];
    assign y[i*BW +: BW] = {b[BW-2:0], 1'b0} ^ (b[BW-1] ? pq_pkg::RED_POLY : '0);
  end
endmodule

// File: rtl/pq_seq_ctrl.sv
`timescale 1ns/1ps
// Tracks position within a run and decides on which beat it closes.
module pq_seq_ctrl #(
  parameter int unsigned CW = pq_pkg::CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          beat,
  input  logic          last,
  input  logic [CW-1:0] ndata,
  output logic          first,
  output logic          close
);
  logic          first_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim_q;
  logic [CW-1:0] lim_eff;
  logic [CW-1:0] idx;
  logic [CW:0]   idx_next;

  assign lim_eff  = first_q ? ndata : lim_q;
  assign idx      = first_q ? '0 : cnt_q;
  assign idx_next = {1'b0, idx} + 1'b1;
  assign close    = last || (idx_next >= {1'b0, lim_eff});
  assign first    = first_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= 1'b1;
      cnt_q   <= '0;
      lim_q   <= '0;
    end else if (beat) begin
      if (close) begin
        first_q <= 1'b1;
        cnt_q   <= '0;
      end else begin
        first_q <= 1'b0;
        cnt_q   <= idx_next[CW-1:0];
        lim_q   <= lim_eff;
      end
    end
  end
endmodule

// File: rtl/pq_accum.sv
`timescale 1ns/1ps
// P and Q accumulators plus the registered result.
module pq_accum #(
  parameter int unsigned DW = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          beat,
  input  logic          first,
  input  logic          close,
  input  logic [DW-1:0] data,
  input  logic [DW-1:0] q_times_x,
  output logic [DW-1:0] q_acc,
  output logic          res_valid,
  output logic [DW-1:0] res_p,
  output logic [DW-1:0] res_q
);
  logic [DW-1:0] p_acc;
  logic [DW-1:0] nxt_p;
  logic [DW-1:0] nxt_q;

  assign nxt_p = first ? data : (p_acc ^ data);
  assign nxt_q = first ? data : (q_times_x ^ data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_acc     <= '0;
      q_acc     <= '0;
      res_p     <= '0;
      res_q     <= '0;
      res_valid <= 1'b0;
    end else begin
      res_valid <= beat && close;
      if (beat) begin
        if (close) begin
          p_acc <= '0;
          q_acc <= '0;
          res_p <= nxt_p;
          res_q <= nxt_q;
        end else begin
          p_acc <= nxt_p;
          q_acc <= nxt_q;
        end
      end
    end
  end
endmodule

// File: rtl/pq_syndrome_engine.sv
`timescale 1ns/1ps
module pq_syndrome_engine #(
  parameter int unsigned LANES   = 16,
  parameter int unsigned COUNT_W = pq_pkg::CNT_W
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [COUNT_W-1:0]             ndata,
  input  logic                           in_valid,
  output logic                           in_ready,
  input  logic [LANES*pq_pkg::BYTE_W-1:0] in_data,
  input  logic                           in_last,
  output logic                           out_valid,
  output logic [LANES*pq_pkg::BYTE_W-1:0] out_p,
  output logic [LANES*pq_pkg::BYTE_W-1:0] out_q
);
  localparam int unsigned DATA_W = LANES * pq_pkg::BYTE_W;

  logic              rdy_q;
  logic              beat;
  logic              first;
  logic              close;
  logic [DATA_W-1:0] q_acc;
  logic [DATA_W-1:0] q_x;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= 1'b1;
  end

  assign in_ready = rdy_q;
  assign beat     = in_valid && rdy_q;

  pq_seq_ctrl #(.CW(COUNT_W)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .beat  (beat),
    .last  (in_last),
    .ndata (ndata),
    .first (first),
    .close (close)
  );

  pq_xtime #(.LANES(LANES)) u_xtime (
    .a (q_acc),
    .y (q_x)
  );

  pq_accum #(.DW(DATA_W)) u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .beat      (beat),
    .first     (first),
    .close     (close),
    .data      (in_data),
    .q_times_x (q_x),
    .q_acc     (q_acc),
    .res_valid (out_valid),
    .res_p     (out_p),
    .res_q     (out_q)
  );
endmodule

// File: rtl/pq_syndrome_chk.sv
`timescale 1ns/1ps
module pq_syndrome_chk #(
  parameter int unsigned DW = 128
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          in_last,
  input logic          out_valid,
  input logic [DW-1:0] out_p,
  input logic [DW-1:0] out_q
);
  // R1: ready stays high once out of reset
  p_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> in_ready);

  // R6: a strobe is always preceded by an accepted beat
  p_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid && in_ready));

  // R6: results hold between strobes
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(out_p) && $stable(out_q)));

  // R8: an accepted last beat always closes the run
  p_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_last) |=> out_valid);

  // R10: idle cycles never produce a strobe
  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> !out_valid);
endmodule

bind pq_syndrome_engine pq_syndrome_chk #(.DW(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_last   (in_last),
  .out_valid (out_valid),
  .out_p     (out_p),
  .out_q     (out_q)
);

// File: tb/sim_pq_syndrome_engine.sv
`timescale 1ns/1ps
module sim_pq_syndrome_engine;
  localparam int LANES = 16;
  localparam int DW    = LANES * 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    ndata = 8'd1;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [DW-1:0] in_data = '0;
  logic          in_last = 1'b0;
  logic          out_valid;
  logic [DW-1:0] out_p;
  logic [DW-1:0] out_q;

  int n_run  = 0;
  int n_fail = 0;

  logic [DW-1:0] w [0:255];
  logic [DW-1:0] got_p;
  logic [DW-1:0] got_q;

  always #2 clk = ~clk;

  pq_syndrome_engine #(.LANES(LANES)) u0 (
    .clk(clk), .rst_n(rst_n), .ndata(ndata), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .out_valid(out_valid), .out_p(out_p), .out_q(out_q)
  );

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] rnd();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  // bit-serial GF(2^8) multiply, polynomial 0x11d
  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [8:0] x;
    logic [7:0] r;
    r = 8'h00;
    x = {1'b0, a};
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r = r ^ x[7:0];
      x = x << 1;
      if (x[8]) x = x ^ 9'h11d;
    end
    return r;
  endfunction

  function automatic logic [7:0] gpow(input int k);
    logic [7:0] r;
    r = 8'h01;
    for (int i = 0; i < k; i++) r = gmul(r, 8'h02);
    return r;
  endfunction

  // drives w[0..nb-1]; closing beat is the final one
  task automatic run_stripe(input string tag, input int nb, input logic [7:0] nd,
                            input logic [7:0] nd_mid, input int last_at, input bit gaps);
    logic [DW-1:0] ep, eq;
    int early;
    ep = '0; eq = '0; early = 0;
    for (int b = 0; b < nb; b++) begin
      logic [7:0] c;
      c = gpow(nb - 1 - b);
      ep = ep ^ w[b];
      for (int l = 0; l < LANES; l++)
        eq[l*8 +: 8] = eq[l*8 +: 8] ^ gmul(c, w[b][l*8 +: 8]);
    end
    for (int b = 0; b < nb; b++) begin
      @(negedge clk);
      if (b > 0 && out_valid) early++;
      if (gaps && b > 0) begin
        in_valid = 1'b0; in_data = rnd(); in_last = 1'b1; ndata = 8'd1;
        @(negedge clk);
        if (out_valid) early++;
      end
      in_valid = 1'b1;
      in_data  = w[b];
      in_last  = (b == last_at);
      ndata    = (b == 0) ? nd : nd_mid;
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0; in_data = rnd();
    got_p = out_p; got_q = out_q;
    chk({tag, " R6 strobe"}, {127'd0, out_valid}, {127'd0, 1'b1});
    chk({tag, " R7 no early close"}, early, 0);
    chk({tag, " R2 P"}, out_p, ep);
    chk({tag, " R3 Q"}, out_q, eq);
    @(negedge clk);
    chk({tag, " R6 pulse ends"}, {127'd0, out_valid}, '0);
    chk({tag, " R6 P held"}, out_p, ep);
    chk({tag, " R6 Q held"}, out_q, eq);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 ready in reset", {127'd0, in_ready}, '0);
    chk("R1 valid in reset", {127'd0, out_valid}, '0);
    chk("R1 P in reset", out_p, '0);
    chk("R1 Q in reset", out_q, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", {127'd0, in_ready}, {127'd0, 1'b1});
  endtask

  task automatic t_xtime();
    w[0] = {8{8'h80, 8'h41}};
    w[1] = '0;
    run_stripe("R4 lanes", 2, 8'd2, 8'd2, -1, 1'b0);
    chk("R4 fixed Q", got_q, {8{8'h1d, 8'h82}});
  endtask

  task automatic t_single();
    w[0] = rnd();
    run_stripe("R5 one disk", 1, 8'd1, 8'd1, -1, 1'b0);
    chk("R5 P==Q", got_p, got_q);
    chk("R5 P==D", got_p, w[0]);
  endtask

  task automatic t_four();
    for (int i = 0; i < 4; i++) w[i] = rnd();
    run_stripe("R3 four disks", 4, 8'd4, 8'd4, -1, 1'b0);
  endtask

  task automatic t_max();
    for (int i = 0; i < 253; i++) w[i] = rnd();
    run_stripe("R7 253 disks", 253, 8'd253, 8'd253, -1, 1'b0);
  endtask

  task automatic t_ndata_change();
    for (int i = 0; i < 3; i++) w[i] = rnd();
    run_stripe("R7 mid change", 3, 8'd3, 8'd9, -1, 1'b0);
  endtask

  task automatic t_last_early();
    for (int i = 0; i < 4; i++) w[i] = rnd();
    run_stripe("R8 early last", 4, 8'd10, 8'd10, 3, 1'b0);
  endtask

  task automatic t_fresh();
    for (int i = 0; i < 5; i++) w[i] = rnd();
    run_stripe("R9 first", 5, 8'd5, 8'd5, -1, 1'b0);
    for (int i = 0; i < 2; i++) w[i] = rnd();
    run_stripe("R9 second", 2, 8'd2, 8'd2, -1, 1'b0);
  endtask

  task automatic t_gaps();
    for (int i = 0; i < 6; i++) w[i] = rnd();
    run_stripe("R10 gaps", 6, 8'd6, 8'd6, -1, 1'b1);
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_xtime();
    t_single();
    t_four();
    t_max();
    t_ndata_change();
    t_last_early();
    t_fresh();
    t_gaps();
    repeat (3) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule